// File: doc/BRIEF.md
# Sparse-Space PCI Address Translator

This block sits between a host processor port that has no byte enables and a PCI bus master. Each host access carries only an address, a write flag and a 32-bit data word. The block works out from the host address which window the access falls into. For the sparse windows it also recovers the PCI address and the transfer size, which are packed into the host address. It then issues one PCI transaction with the right command, byte enables and data lanes, and returns lane-aligned, zero-extended read data to the host.

In sparse memory space the PCI address appears in the host address shifted left by five bits. Bits 4:3 of the host offset carry the transfer size, and the top five PCI address bits come from a host-address extension register that software writes and reads back. The I/O and interrupt-acknowledge windows use the same packing but reach only 24 bits of PCI address. Dense memory space passes the offset straight through and accepts only aligned longwords. An access the block cannot forward completes locally with all-ones data and sets a sticky error flag.

Top module: `sparse_pci_xlat`

## Requirements
- R1: Bits 33:29 of the host address select the window: 01100 is the extension register, 01101 is interrupt acknowledge/special cycle, and 01110 is I/O. When bit 33 is set, bit 32 chooses between sparse memory (bit 32 = 0) and dense memory (bit 32 = 1). All other codes are unmapped.
- R2: In the sparse, I/O and interrupt-acknowledge windows, the PCI address is the window offset shifted right by 5. Offset bits 4:3 give the size: 00 is a byte, 01 is a 16-bit word, 11 is a 32-bit longword.
- R3: A sparse memory access puts offset bits 31:5 on PCI address bits 26:0 and the extension register on bits 31:27.
- R4: I/O and interrupt-acknowledge accesses use offset bits 28:5 as PCI address bits 23:0, with bits 31:24 zero whatever the extension register holds.
- R5: A dense access forwards the low 32 host address bits unchanged as the PCI address, as a longword.
- R6: Byte enables are active low. A byte at lane L drives the inverse of (1<<L). A word drives 4'hC at lane 0 and 4'h3 at lane 2. A longword drives 4'h0.
- R7: Write data is steered so that a byte lands at bits 8L+7:8L and a word at bits 16(L/2)+15:16(L/2), with every other bit zero. A longword passes unchanged.
- R8: Read data returns the byte or word taken from lane L, zero-extended, or the whole longword.
- R9: The extension register responds anywhere in its window. A write stores host data bits 31:27. A read returns the stored value in bits 31:27 with zeros below. Reset clears it, and the next access after the write completes uses the new value.
- R10: No PCI request is made, read data is 32'hFFFFFFFF, and the sticky error flag sets for any of these: an unaligned dense access, sparse size code 10, a word at an odd lane, a longword at a nonzero lane, or an unmapped window.
- R11: Only one PCI transaction is outstanding. While pci_ack is low, the request and its command, address and enables hold steady and host_ready stays low. host_ready pulses for one cycle, the cycle after the acknowledge.
- R12: PCI commands are 0010 for an I/O read, 0011 for an I/O write, 0110 for a memory read, 0111 for a memory write, 0000 for interrupt acknowledge (read) and 0001 for a special cycle (write).
- R13: After reset, host_ready, pci_req and the error flag are low and the extension register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 34 | Host physical address |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| pci_req | output | 1 | PCI transaction request, held until pci_ack |
| pci_cmd | output | 4 | PCI bus command |
| pci_addr | output | 32 | PCI address |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_wdata | output | 32 | Lane-steered write data |
| pci_rdata | input | 32 | PCI read data, sampled with pci_ack |
| pci_ack | input | 1 | PCI transaction complete |
| xlat_err | output | 1 | Sticky error flag |

## Verification
The hardest case to reach from the ports is the hand-off between an extension register write and the sparse access that follows it. The upper PCI bits must reflect the new value at once, while I/O cycles issued afterwards must still ignore it. The bench writes a non-zero pattern to the register and reads it back, then issues a sparse longword read and an I/O byte read and compares both PCI addresses. It also holds pci_ack off for several cycles on chosen accesses, to show the request stays stable and host_ready stays low while the access stalls.

// File: rtl/sparse_xlat_pkg.sv
// Package: shared types and PCI command codes for the sparse-space translator.
// Assumes a 32-bit PCI data path with four byte lanes.
package sparse_xlat_pkg;
    typedef enum logic [2:0] {
        RG_NONE, RG_EXT, RG_IACK, RG_IO, RG_SPARSE, RG_DENSE
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE, SZ_WORD, SZ_LONG
    } xfer_e;

    localparam logic [3:0] CMD_IACK    = 4'h0;
    localparam logic [3:0] CMD_SPECIAL = 4'h1;
    localparam logic [3:0] CMD_IORD    = 4'h2;
    localparam logic [3:0] CMD_IOWR    = 4'h3;
    localparam logic [3:0] CMD_MRD     = 4'h6;
    localparam logic [3:0] CMD_MWR     = 4'h7;
endpackage

// File: rtl/xlat_decode.sv
// Module: xlat_decode
// Purely combinational. Classifies a host address into a window, unpacks the
// sparse PCI address and size code, and forms the command and active-low
// byte enables. Flags accesses that cannot be forwarded.
// Assumes window codes sit in host address bits [HOST_AW-1 -: 5] and that
// SHIFT <= EXT_W, so the unpacked sparse address fits in PCI_AW bits.
module xlat_decode
    import sparse_xlat_pkg::*;
#(
    parameter int HOST_AW = 34,
    parameter int PCI_AW  = 32,
    parameter int EXT_W   = 5,
    parameter int IO_AW   = 24,
    parameter int SHIFT   = 5
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic               we,
    input  logic [EXT_W-1:0]   ext,
    output region_e            region,
    output xfer_e              size,
    output logic [PCI_AW-1:0]  paddr,
    output logic [3:0]         cmd,
    output logic [3:0]         be_n,
    output logic               bad
);
    localparam int SPARSE_LO = PCI_AW - EXT_W;

    logic [4:0]        top;
    logic [PCI_AW-1:0] off;
    logic [1:0]        lane;

    assign top  = addr[HOST_AW-1 -: 5];
    assign off  = addr[PCI_AW-1:0];
    assign lane = paddr[1:0];

    // Window select from the top address bits.
    always_comb begin
        case (top)
            5'b01100: region = RG_EXT;
            5'b01101: region = RG_IACK;
            5'b01110: region = RG_IO;
            default:  region = top[4] ? (top[3] ? RG_DENSE : RG_SPARSE) : RG_NONE;
        endcase
    end

    // Address, command and size unpacking per window.
    always_comb begin
        paddr = '0;
        cmd   = we ? CMD_MWR : CMD_MRD;
        size  = SZ_LONG;
        bad   = 1'b0;
        case (region)
            RG_SPARSE: paddr = {ext, off[SHIFT +: SPARSE_LO]};
            RG_IO: begin
                paddr = PCI_AW'(off[SHIFT +: IO_AW]);
                cmd   = we ? CMD_IOWR : CMD_IORD;
            end
            RG_IACK: begin
                paddr = PCI_AW'(off[SHIFT +: IO_AW]);
                cmd   = we ? CMD_SPECIAL : CMD_IACK;
            end
            RG_DENSE: begin
                paddr = off;
                bad   = (off[1:0] != 2'b00);
            end
            RG_EXT:  bad = 1'b0;
            default: bad = 1'b1;
        endcase
        if (region == RG_SPARSE || region == RG_IO || region == RG_IACK) begin
            case (off[4:3])
                2'b00: size = SZ_BYTE;
                2'b01: begin size = SZ_WORD; bad = lane[0]; end
                2'b11: begin size = SZ_LONG; bad = (lane != 2'b00); end
                default: bad = 1'b1;
            endcase
        end
    end

    // Active-low byte enables from size and lane.
    always_comb begin
        case (size)
            SZ_BYTE: be_n = ~(4'b0001 << lane);
            SZ_WORD: be_n = lane[1] ? 4'h3 : 4'hC;
            default: be_n = 4'h0;
        endcase
    end

    // R6: a forwardable access always enables at least one lane.
    always_comb begin
        if (!bad && region != RG_EXT)
            a_r6_be_live: assert (be_n != 4'hF);
    end
endmodule

// File: rtl/xlat_lanes.sv
// Module: xlat_lanes
// Combinational lane steering. Moves right-aligned host write data onto
// the PCI lane, and extracts and zero-extends PCI read data.
// Assumes a 32-bit data path; a word lane is chosen by lane[1].
module xlat_lanes
    import sparse_xlat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xfer_e              size,
    input  logic [1:0]         lane,
    input  logic [DATA_W-1:0]  wdata_in,
    input  logic [DATA_W-1:0]  rdata_in,
    output logic [DATA_W-1:0]  wdata_out,
    output logic [DATA_W-1:0]  rdata_out
);
    logic [4:0] bsh;
    logic [4:0] wsh;

    assign bsh = {lane, 3'b000};
    assign wsh = {lane[1], 4'b0000};

    // Write lane placement.
    always_comb begin
        case (size)
            SZ_BYTE: wdata_out = {{(DATA_W-8){1'b0}},  wdata_in[7:0]}  << bsh;
            SZ_WORD: wdata_out = {{(DATA_W-16){1'b0}}, wdata_in[15:0]} << wsh;
            default: wdata_out = wdata_in;
        endcase
    end

    // Read lane extraction with zero extension.
    always_comb begin
        case (size)
            SZ_BYTE: rdata_out = (rdata_in >> bsh) & DATA_W'(32'h0000_00FF);
            SZ_WORD: rdata_out = (rdata_in >> wsh) & DATA_W'(32'h0000_FFFF);
            default: rdata_out = rdata_in;
        endcase
    end
endmodule

// File: rtl/sparse_pci_xlat.sv
// Module: sparse_pci_xlat (top)
// Accepts one host access at a time. It either serves it locally (extension
// register, error) or issues one PCI transaction and waits for pci_ack.
// host_ready pulses one cycle in the completion state.
// Assumes host_req and its fields stay steady until host_ready, and that
// the host drops host_req in the cycle it sees host_ready.
module sparse_pci_xlat
    import sparse_xlat_pkg::*;
#(
    parameter int HOST_AW = 34,
    parameter int PCI_AW  = 32,
    parameter int EXT_W   = 5,
    parameter int IO_AW   = 24,
    parameter int SHIFT   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [PCI_AW-1:0]  host_wdata,
    output logic [PCI_AW-1:0]  host_rdata,
    output logic               host_ready,
    output logic               pci_req,
    output logic [3:0]         pci_cmd,
    output logic [PCI_AW-1:0]  pci_addr,
    output logic [3:0]         pci_be_n,
    output logic [PCI_AW-1:0]  pci_wdata,
    input  logic [PCI_AW-1:0]  pci_rdata,
    input  logic               pci_ack,
    output logic               xlat_err
);
    localparam int LOW_W = PCI_AW - EXT_W;

    typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_DONE} state_e;

    state_e             state;
    region_e            d_region;
    xfer_e              d_size;
    xfer_e              size_q;
    logic [PCI_AW-1:0]  d_paddr;
    logic [3:0]         d_cmd;
    logic [3:0]         d_be_n;
    logic               d_bad;
    logic [EXT_W-1:0]   ext_q;
    logic [PCI_AW-1:0]  addr_q;
    logic [3:0]         cmd_q;
    logic [3:0]         be_q;
    logic [PCI_AW-1:0]  wraw_q;
    logic [PCI_AW-1:0]  rdata_q;
    logic [PCI_AW-1:0]  rd_fmt;
    logic               err_q;

    xlat_decode #(
        .HOST_AW(HOST_AW), .PCI_AW(PCI_AW), .EXT_W(EXT_W),
        .IO_AW(IO_AW), .SHIFT(SHIFT)
    ) dec_i (
        .addr(host_addr), .we(host_we), .ext(ext_q),
        .region(d_region), .size(d_size), .paddr(d_paddr),
        .cmd(d_cmd), .be_n(d_be_n), .bad(d_bad)
    );

    xlat_lanes #(.DATA_W(PCI_AW)) lanes_i (
        .size(size_q), .lane(addr_q[1:0]),
        .wdata_in(wraw_q), .rdata_in(pci_rdata),
        .wdata_out(pci_wdata), .rdata_out(rd_fmt)
    );

    // Access sequencing, capture of the PCI fields, local register and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ext_q   <= '0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            cmd_q   <= '0;
            be_q    <= 4'hF;
            wraw_q  <= '0;
            size_q  <= SZ_LONG;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (host_req) begin
                    if (d_bad) begin
                        err_q   <= 1'b1;
                        rdata_q <= '1;
                        state   <= ST_DONE;
                    end else if (d_region == RG_EXT) begin
                        if (host_we)
                            ext_q <= host_wdata[PCI_AW-1 -: EXT_W];
                        rdata_q <= {ext_q, {LOW_W{1'b0}}};
                        state   <= ST_DONE;
                    end else begin
                        addr_q <= d_paddr;
                        cmd_q  <= d_cmd;
                        be_q   <= d_be_n;
                        size_q <= d_size;
                        wraw_q <= host_wdata;
                        state  <= ST_BUS;
                    end
                end
                ST_BUS: if (pci_ack) begin
                    rdata_q <= rd_fmt;
                    state   <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pci_req    = (state == ST_BUS);
    assign host_ready = (state == ST_DONE);
    assign pci_addr   = addr_q;
    assign pci_cmd    = cmd_q;
    assign pci_be_n   = be_q;
    assign host_rdata = rdata_q;
    assign xlat_err   = err_q;

    // R11: an unacknowledged request keeps its fields.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && !pci_ack |=> pci_req && $stable(pci_addr) && $stable(pci_cmd) && $stable(pci_be_n));

    // R11: acknowledge leads to completion on the next cycle.
    a_r11_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && pci_ack |=> host_ready && !pci_req);

    // R11: completion is a single-cycle pulse.
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R10: the error flag never clears outside reset.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_err |=> xlat_err);

    // R10: the access that raises the error completes with all-ones data.
    a_r10_err_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xlat_err) |-> host_ready && (host_rdata == '1) && !pci_req);
endmodule

// File: tb/sparse_pci_xlat_tb_top.sv
`timescale 1ns/1ps
module sparse_pci_xlat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [33:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        pci_req;
    logic [3:0]  pci_cmd;
    logic [31:0] pci_addr;
    logic [3:0]  pci_be_n;
    logic [31:0] pci_wdata;
    logic [31:0] pci_rdata = '0;
    logic        pci_ack = 1'b0;
    logic        xlat_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    sparse_pci_xlat dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .pci_req(pci_req), .pci_cmd(pci_cmd),
        .pci_addr(pci_addr), .pci_be_n(pci_be_n), .pci_wdata(pci_wdata),
        .pci_rdata(pci_rdata), .pci_ack(pci_ack), .xlat_err(xlat_err)
    );

    localparam int NV = 10;
    localparam logic        V_WE  [NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 0};
    localparam logic [33:0] V_AD  [NV] = '{34'h200002460, 34'h200000820, 34'h200004048,
        34'h200006008, 34'h200008018, 34'h1C0007F00, 34'h1C0019F18, 34'h300001000,
        34'h3FFFFFFFC, 34'h1A0000018};
    localparam logic [31:0] V_WD  [NV] = '{0, 32'h5A, 0, 32'hBEEF, 0, 0, 32'h80000000, 0,
        32'h12345678, 0};
    localparam logic [31:0] V_PA  [NV] = '{32'h123, 32'h41, 32'h202, 32'h300, 32'h400,
        32'h3F8, 32'hCF8, 32'h1000, 32'hFFFFFFFC, 32'h0};
    localparam logic [3:0]  V_CM  [NV] = '{4'h6, 4'h7, 4'h6, 4'h7, 4'h6, 4'h2, 4'h3, 4'h6, 4'h7, 4'h0};
    localparam logic [3:0]  V_BE  [NV] = '{4'h7, 4'hD, 4'h3, 4'hC, 4'h0, 4'hE, 4'h0, 4'h0, 4'h0, 4'h0};
    localparam logic [31:0] V_PW  [NV] = '{0, 32'h00005A00, 0, 32'h0000BEEF, 0, 0,
        32'h80000000, 0, 32'h12345678, 0};
    localparam logic [31:0] V_RSP [NV] = '{32'hAABBCCDD, 0, 32'h1234ABCD, 0, 32'hCAFEF00D,
        32'h11223344, 0, 32'h0BADF00D, 0, 32'h00000021};
    localparam logic [31:0] V_RD  [NV] = '{32'hAA, 0, 32'h1234, 0, 32'hCAFEF00D,
        32'h44, 0, 32'h0BADF00D, 0, 32'h21};

    task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One host access; if fwd, check the PCI side and acknowledge after dly cycles.
    task automatic access(input logic we, input logic [33:0] a, input logic [31:0] wd,
                          input bit fwd, input logic [31:0] pa, input logic [3:0] cm,
                          input logic [3:0] be, input logic [31:0] pw,
                          input logic [31:0] rsp, input int dly, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        @(negedge clk);
        if (fwd) begin
            chk(pci_req === 1'b1, "R11 request raised", 34'(pci_req), 34'd1);
            chk(pci_addr === pa, "R2 R3 R4 R5 PCI address", 34'(pci_addr), 34'(pa));
            chk(pci_cmd === cm, "R12 PCI command", 34'(pci_cmd), 34'(cm));
            chk(pci_be_n === be, "R6 byte enables", 34'(pci_be_n), 34'(be));
            if (we) chk(pci_wdata === pw, "R7 write lanes", 34'(pci_wdata), 34'(pw));
            for (int k = 0; k < dly; k++) begin
                chk(host_ready === 1'b0, "R11 ready low while stalled", 34'(host_ready), 34'd0);
                @(negedge clk);
                chk(pci_req === 1'b1 && pci_addr === pa, "R11 request held", 34'(pci_addr), 34'(pa));
            end
            pci_ack = 1'b1; pci_rdata = rsp;
            @(negedge clk);
            pci_ack = 1'b0;
        end else begin
            chk(pci_req === 1'b0, "R10 R9 not forwarded", 34'(pci_req), 34'd0);
        end
        chk(host_ready === 1'b1, "R11 completion pulse", 34'(host_ready), 34'd1);
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk(host_ready === 1'b0, "R11 pulse ends", 34'(host_ready), 34'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        chk(host_ready === 1'b0, "R13 ready after reset", 34'(host_ready), 34'd0);
        chk(pci_req === 1'b0, "R13 req after reset", 34'(pci_req), 34'd0);
        chk(xlat_err === 1'b0, "R13 error after reset", 34'(xlat_err), 34'd0);
        access(1'b0, 34'h180000000, 0, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'h0, "R13 extension reads zero", 34'(got), 34'd0);

        // Vector table: R1 R2 R5 R6 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            access(V_WE[i], V_AD[i], V_WD[i], 1'b1, V_PA[i], V_CM[i], V_BE[i], V_PW[i],
                   V_RSP[i], i % 3, got);
            if (!V_WE[i]) chk(got === V_RD[i], "R8 read lane extraction", 34'(got), 34'(V_RD[i]));
        end

        // R9 extension register write and readback
        access(1'b1, 34'h180000040, 32'hA8000000, 1'b0, 0, 0, 0, 0, 0, 0, got);
        access(1'b0, 34'h180000000, 0, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'hA8000000, "R9 extension readback", 34'(got), 34'hA8000000);
        // R3 upper bits merged on the next sparse access
        access(1'b0, 34'h200008018, 0, 1'b1, 32'hA8000400, 4'h6, 4'h0, 0, 32'h55, 0, got);
        chk(got === 32'h55, "R3 sparse longword data", 34'(got), 34'h55);
        // R4 I/O ignores the extension register
        access(1'b0, 34'h1C0007F00, 0, 1'b1, 32'h3F8, 4'h2, 4'hE, 0, 32'h99, 4, got);
        chk(got === 32'h99, "R4 I/O byte data", 34'(got), 34'h99);
        chk(xlat_err === 1'b0, "R10 no error yet", 34'(xlat_err), 34'd0);

        // R10 error cases
        access(1'b0, 34'h300000002, 0, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'hFFFFFFFF, "R10 dense misaligned data", 34'(got), 34'hFFFFFFFF);
        chk(xlat_err === 1'b1, "R10 error set", 34'(xlat_err), 34'd1);
        access(1'b0, 34'h200000010, 0, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'hFFFFFFFF, "R10 reserved size code", 34'(got), 34'hFFFFFFFF);
        access(1'b0, 34'h200000028, 0, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'hFFFFFFFF, "R10 word at odd lane", 34'(got), 34'hFFFFFFFF);
        access(1'b1, 34'h1E0000000, 32'h1, 1'b0, 0, 0, 0, 0, 0, 0, got);
        chk(got === 32'hFFFFFFFF, "R1 R10 unmapped window", 34'(got), 34'hFFFFFFFF);
        // R10 flag stays set after a good access
        access(1'b0, 34'h300000000, 0, 1'b1, 32'h0, 4'h6, 4'h0, 0, 32'h7, 0, got);
        chk(xlat_err === 1'b1, "R10 error sticky", 34'(xlat_err), 34'd1);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule